// File: doc/BRIEF.md
# Integrating ADC Conversion Sequencer

This block controls an external integrating converter front end. Each conversion runs as a series of integrations. Before every integration the sequencer closes the capacitor discharge switch for a programmed number of clock cycles. It then selects a source and counts, in clock cycles, how long the front end holds its integrate output high. Every pulse carries a fixed offset, so a zero input still gives a nonzero width. For that reason the block also measures a zero-scale (ground) pulse and a reference pulse. It forms the result as `REF_CODE * (Tin - Tgnd) / (Tref - Tgnd)` with a sequential restoring divider.

The ground and reference counts are a calibration pair that is kept between conversions. The pair is refreshed only after a programmable number of conversions, or after an error. An integration whose pulse never rises, or one that stays high longer than a programmable limit, ends the conversion with an error. A calibration in which the reference pulse is not longer than the ground pulse also ends with an error. At the end of every conversion, with or without an error, the block reports the channel on a single-cycle valid strobe and returns the select bus to its idle code.

Top module: `integ_adc_seq`

## Requirements
- R1: `mode_sel` bit 0, bit 1 and bit 2 drive the front-end select lines C0, C1 and C2. Value 0 selects discharge, 1 selects ground, 2 selects reference, 7 selects idle, and channel k (0..3) is selected by value k+3.
- R2: After reset, and on the cycle after every `result_valid`, `mode_sel` is 7 and `busy` is low.
- R3: Value 0 is held on `mode_sel` for at least max(`discharge_cycles`,1) consecutive cycles right before every selection of ground, reference or a channel.
- R4: A conversion that recalibrates selects ground, then reference, then the requested channel. A conversion that does not recalibrate selects only the channel.
- R5: A pulse count equals the number of clock cycles in which `integ_in` is high during that integration.
- R6: `result` = floor(REF_CODE*(Tin-Tgnd)/(Tref-Tgnd)), saturated to all ones at RES_W bits, and 0 when Tin <= Tgnd.
- R7: Recalibration happens when no valid pair is held or when at least max(`recal_interval`,1) error-free conversions have used the current pair. Otherwise the stored pair is reused.
- R8: If the pulse has not risen `timeout_limit` cycles after its source is selected, or if it is high for more than `timeout_limit` cycles, the conversion ends with `result_err`=1. A width equal to the limit is accepted.
- R9: A calibration with Tref <= Tgnd ends with `result_err`=1. Every error gives `result`=0 and drops the stored pair.
- R10: `result_valid` is high for exactly one cycle per conversion, with `result_chan` equal to the channel latched at start. A `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a conversion (accepted when idle) |
| start_chan | input | 2 | Channel to convert |
| discharge_cycles | input | CNT_W | Discharge hold length in cycles |
| timeout_limit | input | CNT_W | Rise wait and pulse width limit |
| recal_interval | input | RC_W | Conversions per calibration pair |
| integ_in | input | 1 | Integrate pulse from the front end |
| mode_sel | output | 3 | Front-end select lines {C2,C1,C0} |
| busy | output | 1 | Conversion in progress |
| result_valid | output | 1 | One-cycle completion strobe |
| result_err | output | 1 | Conversion failed |
| result_chan | output | 2 | Channel of the reported result |
| result | output | RES_W | Scaled ratio code |

## Verification
A stored ground or reference count that is wrong does not show as a bad select sequence. It shows in the result code of the same conversion, and also in every later conversion that reuses the pair, until the next recalibration. A wrong calibration-interval counter shows on the select bus within one conversion: the ground and reference selections appear or go missing. A divider fault, or a fault in the discharge timing, shows at the next valid strobe or at the next change of the select bus.

// File: rtl/integ_adc_seq.sv
module integ_adc_seq #(
  parameter int CNT_W    = 16,
  parameter int RES_W    = 12,
  parameter int REF_CODE = 4000,
  parameter int RC_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       start_chan,
  input  logic [CNT_W-1:0] discharge_cycles,
  input  logic [CNT_W-1:0] timeout_limit,
  input  logic [RC_W-1:0]  recal_interval,
  input  logic             integ_in,
  output logic [2:0]       mode_sel,
  output logic             busy,
  output logic             result_valid,
  output logic             result_err,
  output logic [1:0]       result_chan,
  output logic [RES_W-1:0] result
);

  localparam int NW   = CNT_W + RES_W;
  localparam int BC_W = $clog2(NW + 1);
  localparam logic [NW-1:0] REF_N = NW'(REF_CODE);

  typedef enum logic [2:0] {S_IDLE, S_DIS, S_RISE, S_HIGH, S_DIV, S_DONE} st_t;
  typedef enum logic [1:0] {PH_G, PH_R, PH_I} ph_t;

  st_t st;
  ph_t ph;
  logic [1:0]       chan_q, sync_q;
  logic [CNT_W-1:0] dis_q, to_q, tmr, cnt, tg, tr, den, rem;
  logic [NW-1:0]    quo;
  logic [BC_W-1:0]  bitc;
  logic [RC_W-1:0]  conv_cnt;
  logic             cal_ok, err_q;
  logic [RES_W-1:0] res_q;

  wire              s_in    = sync_q[1];
  wire [CNT_W-1:0]  dis_eff = (dis_q == '0) ? CNT_W'(1) : dis_q;
  wire [RC_W-1:0]   rc_eff  = (recal_interval == '0) ? RC_W'(1) : recal_interval;
  wire              need_cal = !cal_ok || (conv_cnt >= rc_eff);

  wire [CNT_W:0]    dv_sh  = {rem, quo[NW-1]};
  wire              dv_ge  = dv_sh >= {1'b0, den};
  wire [CNT_W:0]    dv_sub = dv_sh - {1'b0, den};
  wire [NW-1:0]     quo_nx = {quo[NW-2:0], dv_ge};
  wire [CNT_W-1:0]  rem_nx = dv_ge ? dv_sub[CNT_W-1:0] : dv_sh[CNT_W-1:0];
  wire [NW-1:0]     num    = {{RES_W{1'b0}}, cnt - tg} * REF_N;

  assign busy         = (st != S_IDLE);
  assign result_valid = (st == S_DONE);
  assign result_err   = err_q;
  assign result_chan  = chan_q;
  assign result       = res_q;

  always_comb begin
    case (st)
      S_DIS:          mode_sel = 3'd0;
      S_RISE, S_HIGH: case (ph)
                        PH_G:    mode_sel = 3'd1;
                        PH_R:    mode_sel = 3'd2;
                        default: mode_sel = {1'b0, chan_q} + 3'd3;
                      endcase
      default:        mode_sel = 3'd7;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], integ_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_G; chan_q <= '0;
      dis_q <= '0; to_q <= '0; tmr <= '0; cnt <= '0;
      tg <= '0; tr <= '0; den <= '0; rem <= '0; quo <= '0; bitc <= '0;
      conv_cnt <= '0; cal_ok <= 1'b0; err_q <= 1'b0; res_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          chan_q <= start_chan;
          dis_q  <= discharge_cycles;
          to_q   <= timeout_limit;
          err_q  <= 1'b0;
          tmr    <= '0;
          ph     <= need_cal ? PH_G : PH_I;
          if (need_cal) conv_cnt <= '0;
          st     <= S_DIS;
        end
        S_DIS: begin
          if (tmr >= dis_eff - CNT_W'(1)) begin
            tmr <= '0;
            st  <= S_RISE;
          end else tmr <= tmr + CNT_W'(1);
        end
        S_RISE: begin
          if (s_in) begin
            cnt <= CNT_W'(1);
            st  <= S_HIGH;
          end else if (tmr >= to_q) begin
            err_q <= 1'b1; cal_ok <= 1'b0; res_q <= '0; st <= S_DONE;
          end else tmr <= tmr + CNT_W'(1);
        end
        S_HIGH: begin
          if (s_in) begin
            if (cnt >= to_q) begin
              err_q <= 1'b1; cal_ok <= 1'b0; res_q <= '0; st <= S_DONE;
            end else cnt <= cnt + CNT_W'(1);
          end else begin
            tmr <= '0;
            case (ph)
              PH_G: begin
                tg <= cnt; ph <= PH_R; st <= S_DIS;
              end
              PH_R: begin
                if (cnt <= tg) begin
                  err_q <= 1'b1; cal_ok <= 1'b0; res_q <= '0; st <= S_DONE;
                end else begin
                  tr <= cnt; cal_ok <= 1'b1; ph <= PH_I; st <= S_DIS;
                end
              end
              default: begin
                if (cnt <= tg) begin
                  res_q <= '0; st <= S_DONE;
                end else begin
                  quo  <= num;
                  den  <= tr - tg;
                  rem  <= '0;
                  bitc <= '0;
                  st   <= S_DIV;
                end
              end
            endcase
          end
        end
        S_DIV: begin
          quo  <= quo_nx;
          rem  <= rem_nx;
          bitc <= bitc + BC_W'(1);
          if (bitc == BC_W'(NW - 1)) begin
            res_q <= (|quo_nx[NW-1:RES_W]) ? {RES_W{1'b1}} : quo_nx[RES_W-1:0];
            st    <= S_DONE;
          end
        end
        S_DONE: begin
          if (!err_q && conv_cnt != {RC_W{1'b1}}) conv_cnt <= conv_cnt + RC_W'(1);
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CNT_W:0] dis_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                dis_run <= '0;
    else if (mode_sel == 3'd0) dis_run <= (dis_run == '1) ? dis_run : dis_run + 1'b1;
    else                       dis_run <= '0;

  AST_DISCHARGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RISE && $past(st) == S_DIS) |-> dis_run >= {1'b0, dis_eff}); // R3
  AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid); // R10
  AST_IDLE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> (mode_sel == 3'd7 && !busy)); // R2
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && result_err) |-> result == '0); // R9
  AST_DIV_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DIV) |-> (cal_ok && tr > tg)); // R9
  AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIGH) |-> cnt <= to_q); // R8

endmodule

// File: tb/integ_adc_seq_bench.sv
module integ_adc_seq_bench;
  localparam int CNT_W = 16, RES_W = 12, REF_CODE = 4000, RC_W = 8;

  logic clk = 0, rst_n = 0, start = 0, integ_in = 0;
  logic [1:0] start_chan = 0;
  logic [CNT_W-1:0] discharge_cycles = 4, timeout_limit = 1000;
  logic [RC_W-1:0] recal_interval = 3;
  logic [2:0] mode_sel;
  logic busy, result_valid, result_err;
  logic [1:0] result_chan;
  logic [RES_W-1:0] result;

  integ_adc_seq #(.CNT_W(CNT_W), .RES_W(RES_W), .REF_CODE(REF_CODE), .RC_W(RC_W)) u_integ_adc_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_chan(start_chan),
    .discharge_cycles(discharge_cycles), .timeout_limit(timeout_limit),
    .recal_interval(recal_interval), .integ_in(integ_in), .mode_sel(mode_sel),
    .busy(busy), .result_valid(result_valid), .result_err(result_err),
    .result_chan(result_chan), .result(result));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int w_g = 40, w_r = 300, rise_dly = 2;
  int w_ch [4];
  bit dead = 0;
  bit m_cal_ok = 0; int m_since = 0, m_tg = 0, m_tr = 0;
  int log_v [8]; int log_n = 0; int run = 0; int prev_mode = 7; bit dis_bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_res(input int tg, input int tr, input int ti);
    longint q;
    if (ti <= tg) return 0;
    q = (longint'(ti - tg) * REF_CODE) / (tr - tg);
    return (q > 4095) ? 4095 : q;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // front-end model: one pulse per entry into a measurement selection
  initial begin
    bit armed = 0;
    forever begin
      @(negedge clk);
      if (mode_sel != 0 && mode_sel != 7 && !armed) begin
        int w;
        armed = 1;
        w = (mode_sel == 1) ? w_g : (mode_sel == 2) ? w_r : w_ch[int'(mode_sel) - 3];
        if (!dead) begin
          repeat (rise_dly) @(negedge clk);
          integ_in = 1;
          repeat (w) @(negedge clk);
          integ_in = 0;
        end
      end
      if (mode_sel == 0 || mode_sel == 7) armed = 0;
    end
  end

  // select-bus monitor
  always @(negedge clk) begin
    int de;
    de = (discharge_cycles == 0) ? 1 : int'(discharge_cycles);
    if (int'(mode_sel) != prev_mode && mode_sel != 0 && mode_sel != 7) begin
      if (log_n < 8) begin log_v[log_n] = int'(mode_sel); log_n++; end
      if (prev_mode != 0 || run < de) dis_bad = 1;
    end
    run = (mode_sel == 0) ? run + 1 : 0;
    prev_mode = int'(mode_sel);
  end

  task automatic conv(input int ch, input bit poke);
    int lim, rc, n; bit need, e, got; int ti;
    lim = int'(timeout_limit);
    rc = (recal_interval == 0) ? 1 : int'(recal_interval);
    need = !m_cal_ok || (m_since >= rc);
    ti = w_ch[ch];
    e = dead;
    if (need && (w_g > lim || w_r > lim || w_r <= w_g)) e = 1;
    if (ti > lim) e = 1;
    if (!e && need) begin m_tg = w_g; m_tr = w_r; end
    log_n = 0; dis_bad = 0;
    @(negedge clk);
    start_chan = 2'(ch); start = 1;
    @(negedge clk);
    start = 0;
    got = 0; n = 0;
    while (!got && n < 20000) begin
      if (poke && n == 20) begin start = 1; start_chan = 2'(ch ^ 2); end
      else start = 0;
      if (result_valid) got = 1;
      else begin @(negedge clk); n++; end
    end
    start = 0;
    chk(got, "R10 valid seen", got, 1);
    chk(result_err == e, "R8/R9 error flag", result_err, e);
    chk(result_chan == 2'(ch), "R10 channel", result_chan, ch);
    if (e) chk(result == 0, "R9 zero on error", result, 0);
    else begin
      chk(result == RES_W'(exp_res(m_tg, m_tr, ti)), "R5/R6 result", result, exp_res(m_tg, m_tr, ti));
      if (need) begin
        chk(log_n == 3 && log_v[0] == 1 && log_v[1] == 2 && log_v[2] == ch + 3,
            "R4/R7 calibrating order", log_n, 3);
      end else begin
        chk(log_n == 1 && log_v[0] == ch + 3, "R7 reuse pair", log_n, 1);
      end
      chk(log_v[log_n-1] == ch + 3, "R1 channel code", log_v[log_n-1], ch + 3);
    end
    chk(!dis_bad, "R3 discharge hold", dis_bad, 0);
    @(negedge clk);
    chk(!result_valid, "R10 single cycle", result_valid, 0);
    chk(mode_sel == 7 && !busy, "R2 idle after", mode_sel, 7);
    if (poke) begin
      got = 0;
      repeat (300) begin @(negedge clk); if (result_valid || busy) got = 1; end
      chk(!got, "R10 start while busy ignored", got, 0);
    end
    if (e) begin m_cal_ok = 0; end
    else if (need) begin m_cal_ok = 1; m_since = 1; end
    else m_since++;
    repeat (3) @(negedge clk);
    while (integ_in) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    w_ch[0] = 200; w_ch[1] = 100; w_ch[2] = 40; w_ch[3] = 450;
    repeat (3) @(negedge clk);
    chk(mode_sel == 7, "R2 reset mode", mode_sel, 7);
    chk(!busy && !result_valid, "R2 reset idle", busy, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    conv(0, 0);
    conv(1, 0);
    conv(2, 0);
    conv(3, 0);
    conv(1, 1);
    w_ch[2] = 20; conv(2, 0);
    timeout_limit = 50; w_g = 10; w_r = 40; recal_interval = 1;
    w_ch[0] = 50; conv(0, 0);
    w_ch[0] = 51; conv(0, 0);
    w_r = 10; conv(1, 0);
    w_r = 40; dead = 1; conv(2, 0);
    dead = 0; conv(2, 0);
    discharge_cycles = 0; conv(3, 0);
    timeout_limit = 1000;
    for (int i = 0; i < 40; i++) begin
      int ch;
      ch = int'($urandom % 4);
      w_g = 20 + int'($urandom % 60);
      w_r = w_g + 50 + int'($urandom % 300);
      w_ch[ch] = 1 + int'($urandom % 450);
      discharge_cycles = CNT_W'($urandom % 16);
      recal_interval = RC_W'($urandom % 5);
      rise_dly = 1 + int'($urandom % 5);
      conv(ch, 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule